// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block maps a 32-bit system address onto one of eight external-memory chip selects. Each chip select owns a small window word with three fields: a 6-bit base, a 4-bit size code and an enable bit. It also owns a 2-bit device-type word. The register copy of these words is updated through a simple write port. The decode from address to select is purely combinational from the stored copy, so a bus master sees the select in the same cycle it presents the address.

For the selected window the block reports which back-end port should take the access: the NOR-style memory port, the NAND data port, or the prefetch FIFO port. A NAND window is routed to the FIFO when the prefetch engine is on and its chip-select field names that window. The block also raises a per-window flag for illegal size codes and a flag for addresses claimed by more than one enabled window. When several windows claim an address, the lowest-numbered one wins.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, window 0 is enabled with base 0 and size code 0xF. Windows 1 to 7 are disabled with size code 0xF. All device types are 0 (NOR). So an address 0x00xxxxxx selects chip select 0 and 0x01000000 selects nothing.
- R2: Window i hits when it is enabled, address bits 31:30 are zero, and (addr[29:24] AND {2'b11, size}) equals (base AND {2'b11, size}). Address bits 23:0 never affect the decode.
- R3: The window span is ((0x0FFFFFFF with bits 27:24 cleared where the size code is 1) + 1). Code 0xF gives 16 MB, 0xE 32 MB, 0xC 64 MB, 0x8 128 MB and 0x0 256 MB.
- R4: bad_mask[i] is 1 when window i is enabled and its size code is not 0x8, 0xC, 0xE or 0xF. Code 0x0 is also legal while zero_mask_ok is 1. A disabled window is never flagged.
- R5: A write with cfg_kind=0 keeps only bits 0xF7F of cfg_wdata: size = bits 11:8, enable = bit 6, base = bits 5:0. Bits 31:12 and bit 7 have no effect. The stored copy is updated only when a kept bit changes. The new decode is visible from the clock edge that takes the write.
- R6: A window whose enable bit is 0 never drives its select, whatever its base and size.
- R7: When two or more enabled windows hit, overlap is 1 and cs_sel holds only the lowest-numbered hitting window. Otherwise overlap is 0.
- R8: A write with cfg_kind=1 keeps bits 11:10 as the device type. For an enabled window, win_tgt is 3 (FIFO) when the type is 2, pf_on=1 and pf_cs equals the window number. It is 2 (NAND data) when the type is 2 otherwise, and 1 (NOR) for any other type. A disabled window shows 0.
- R9: cs_sel is one-hot or zero. tgt is 0 when cs_sel is zero, and otherwise equals the win_tgt of the selected window (0 none, 1 NOR, 2 NAND, 3 FIFO).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = window word, 1 = device-type word |
| cfg_idx | input | 3 | Chip select addressed by the write |
| cfg_wdata | input | 32 | Write data |
| pf_on | input | 1 | Prefetch engine enabled |
| pf_cs | input | 3 | Chip select claimed by the prefetch engine |
| zero_mask_ok | input | 1 | Accept size code 0x0 (256 MB) as legal |
| addr | input | 32 | System address to decode |
| cs_sel | output | 8 | One-hot chip-select vector |
| tgt | output | 2 | Back-end port for the selected window |
| win_tgt | output | 16 | Per-window back-end port, two bits per window |
| bad_mask | output | 8 | Per-window illegal size-code flag |
| overlap | output | 1 | More than one enabled window hits addr |

## Verification
A corrupted stored field shows at the ports one clock after the write that caused it. A wrong base or size moves the hit boundaries on every 16 MB step of an address sweep. A stuck enable bit either opens a window or removes it. A bad priority or lost overlap shows only on addresses inside two windows. A wrong route shows on win_tgt at once, without any address. So each full sweep of the top address byte, taken after each configuration change, exposes the fault within that sweep.

// File: rtl/cswin_pkg.sv
package cswin_pkg;
    localparam int ADDR_SHIFT = 24;
    localparam int BASE_W     = 6;
    localparam int MASK_W     = 4;
    localparam int MASK_LSB   = 8;
    localparam int VALID_BIT  = 6;
    localparam int DEV_LSB    = 10;
    localparam int DEV_W      = 2;
    localparam logic [DEV_W-1:0] DEV_NAND = 2'd2;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_NOR  = 2'd1,
        TGT_NAND = 2'd2,
        TGT_FIFO = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              valid;
        logic [BASE_W-1:0] base;
    } win_cfg_t;
endpackage

// File: rtl/cswin_cfg_bank.sv
module cswin_cfg_bank
    import cswin_pkg::*;
#(
    parameter int N_CS   = 8,
    parameter int WORD_W = 32,
    localparam int CSW   = $clog2(N_CS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic                        kind,
    input  logic [CSW-1:0]              idx,
    input  logic [WORD_W-1:0]           wdata,
    output win_cfg_t [N_CS-1:0]         cfg_q,
    output logic [N_CS-1:0][DEV_W-1:0]  dev_q
);
    win_cfg_t new_cfg;
    logic     unused_wbits;

    assign new_cfg.mask  = wdata[MASK_LSB +: MASK_W];
    assign new_cfg.valid = wdata[VALID_BIT];
    assign new_cfg.base  = wdata[BASE_W-1:0];
    assign unused_wbits  = ^{wdata[WORD_W-1:MASK_LSB+MASK_W], wdata[VALID_BIT+1]};

    for (genvar g = 0; g < N_CS; g++) begin : g_win
        localparam win_cfg_t RST_CFG = '{mask: '1, valid: 1'(g == 0), base: '0};
        win_cfg_t         cfg_r;
        logic [DEV_W-1:0] dev_r;
        logic             hit_idx, win_upd, dev_upd;

        assign hit_idx = we && (idx == CSW'(g));
        // only a change of a kept bit moves the stored copy
        assign win_upd = hit_idx && !kind && (new_cfg != cfg_r);
        assign dev_upd = hit_idx && kind && (wdata[DEV_LSB +: DEV_W] != dev_r);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_r <= RST_CFG;
                dev_r <= '0;
            end else begin
                if (win_upd) cfg_r <= new_cfg;
                if (dev_upd) dev_r <= wdata[DEV_LSB +: DEV_W];
            end
        end

        assign cfg_q[g] = cfg_r;
        assign dev_q[g] = dev_r;

        assert_cfg_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_idx && !kind) |=> (cfg_r == $past(new_cfg)));

        assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> ((cfg_r == RST_CFG) && (dev_r == '0)));
    end
endmodule

// File: rtl/cswin_match.sv
module cswin_match
    import cswin_pkg::*;
#(
    parameter int IDX  = 0,
    parameter int CSW  = 3,
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0]  addr_hi,
    input  win_cfg_t         cfg,
    input  logic [DEV_W-1:0] dev,
    input  logic             pf_on,
    input  logic [CSW-1:0]   pf_cs,
    input  logic             zero_ok,
    output logic             hit,
    output logic             bad,
    output logic [1:0]       route
);
    logic [BASE_W-1:0] amask;
    logic              in_space, legal;
    tgt_e              route_e;

    assign amask    = {{(BASE_W-MASK_W){1'b1}}, cfg.mask};
    assign in_space = (addr_hi[HI_W-1:BASE_W] == '0);
    assign hit      = cfg.valid && in_space &&
                      ((addr_hi[BASE_W-1:0] & amask) == (cfg.base & amask));

    always_comb begin
        unique case (cfg.mask)
            4'h8, 4'hC, 4'hE, 4'hF: legal = 1'b1;
            4'h0:                   legal = zero_ok;
            default:                legal = 1'b0;
        endcase
    end
    assign bad = cfg.valid && !legal;

    always_comb begin
        if (!cfg.valid)
            route_e = TGT_NONE;
        else if (dev == DEV_NAND)
            route_e = (pf_on && (pf_cs == CSW'(IDX))) ? TGT_FIFO : TGT_NAND;
        else
            route_e = TGT_NOR;
    end
    assign route = route_e;
endmodule

// File: rtl/cswin_arbiter.sv
module cswin_arbiter
    import cswin_pkg::*;
#(
    parameter int N_CS = 8
) (
    input  logic [N_CS-1:0]       hits,
    input  logic [N_CS-1:0][1:0]  routes,
    output logic [N_CS-1:0]       sel,
    output logic [1:0]            tgt,
    output logic                  overlap
);
    // isolate lowest set bit; any second bit means a collision
    assign sel     = hits & (~hits + 1'b1);
    assign overlap = |(hits & (hits - 1'b1));

    always_comb begin
        tgt = TGT_NONE;
        for (int i = 0; i < N_CS; i++) begin
            if (sel[i]) tgt = routes[i];
        end
    end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import cswin_pkg::*;
#(
    parameter int N_CS   = 8,
    parameter int WORD_W = 32,
    localparam int CSW   = $clog2(N_CS),
    localparam int HI_W  = WORD_W - ADDR_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_kind,
    input  logic [CSW-1:0]      cfg_idx,
    input  logic [WORD_W-1:0]   cfg_wdata,
    input  logic                pf_on,
    input  logic [CSW-1:0]      pf_cs,
    input  logic                zero_mask_ok,
    input  logic [WORD_W-1:0]   addr,
    output logic [N_CS-1:0]     cs_sel,
    output logic [1:0]          tgt,
    output logic [2*N_CS-1:0]   win_tgt,
    output logic [N_CS-1:0]     bad_mask,
    output logic                overlap
);
    win_cfg_t [N_CS-1:0]         cfg_q;
    logic [N_CS-1:0][DEV_W-1:0]  dev_q;
    logic [N_CS-1:0]             hits;
    logic [N_CS-1:0][1:0]        routes;
    logic                        unused_low;

    assign unused_low = ^addr[ADDR_SHIFT-1:0];

    cswin_cfg_bank #(.N_CS(N_CS), .WORD_W(WORD_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .kind  (cfg_kind),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q),
        .dev_q (dev_q)
    );

    for (genvar g = 0; g < N_CS; g++) begin : g_match
        cswin_match #(.IDX(g), .CSW(CSW), .HI_W(HI_W)) u_match (
            .addr_hi (addr[WORD_W-1:ADDR_SHIFT]),
            .cfg     (cfg_q[g]),
            .dev     (dev_q[g]),
            .pf_on   (pf_on),
            .pf_cs   (pf_cs),
            .zero_ok (zero_mask_ok),
            .hit     (hits[g]),
            .bad     (bad_mask[g]),
            .route   (routes[g])
        );
        assign win_tgt[2*g +: 2] = routes[g];
    end

    cswin_arbiter #(.N_CS(N_CS)) u_arb (
        .hits    (hits),
        .routes  (routes),
        .sel     (cs_sel),
        .tgt     (tgt),
        .overlap (overlap)
    );

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_sel));

    assert_idle_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_sel == '0) |-> (tgt == TGT_NONE));

    assert_overlap_selects_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |-> (cs_sel != '0));

    assert_fifo_claimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_FIFO) |-> (pf_on && cs_sel[pf_cs]));
endmodule

// File: tb/test_cs_window_decoder.sv
`timescale 1ns/1ps
module test_cs_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_kind;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic        pf_on;
    logic [2:0]  pf_cs;
    logic        zero_mask_ok;
    logic [31:0] addr;
    logic [7:0]  cs_sel;
    logic [1:0]  tgt;
    logic [15:0] win_tgt;
    logic [7:0]  bad_mask;
    logic        overlap;

    int n_run  = 0;
    int n_fail = 0;

    logic [5:0] mb [8];
    logic [3:0] mm [8];
    logic       mv [8];
    logic [1:0] mt [8];

    always #2 clk = ~clk;

    cs_window_decoder i_cs_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .pf_on(pf_on), .pf_cs(pf_cs),
        .zero_mask_ok(zero_mask_ok), .addr(addr), .cs_sel(cs_sel), .tgt(tgt),
        .win_tgt(win_tgt), .bad_mask(bad_mask), .overlap(overlap)
    );

    task automatic chk(input string rq, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mdl_hits(input logic [31:0] a);
        logic [7:0] h = '0;
        for (int i = 0; i < 8; i++) begin
            longint unsigned sz, au, bu;
            sz = (64'h0FFF_FFFF & ~(64'(mm[i]) << 24)) + 1;
            au = 64'(a);
            bu = 64'(mb[i]) << 24;
            if (mv[i] && a < 32'h4000_0000 && (au / sz) == (bu / sz)) h[i] = 1'b1;
        end
        return h;
    endfunction

    function automatic logic [1:0] mdl_route(input int i);
        if (!mv[i]) return 2'd0;
        if (mt[i] == 2'd2) return (pf_on && pf_cs == 3'(i)) ? 2'd3 : 2'd2;
        return 2'd1;
    endfunction

    function automatic logic mdl_bad(input int i);
        logic ok;
        ok = (mm[i] == 4'h8) || (mm[i] == 4'hC) || (mm[i] == 4'hE) || (mm[i] == 4'hF) ||
             (mm[i] == 4'h0 && zero_mask_ok);
        return mv[i] && !ok;
    endfunction

    task automatic wr_win(input int i, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 1'b0; cfg_idx = 3'(i); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        mb[i] = w[5:0]; mv[i] = w[6]; mm[i] = w[11:8];
    endtask

    task automatic wr_dev(input int i, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 1'b1; cfg_idx = 3'(i); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        mt[i] = w[11:10];
    endtask

    task automatic chk_static(input string rq);
        #1;
        for (int i = 0; i < 8; i++) begin
            chk(rq, $sformatf("win_tgt[%0d]", i), 64'(win_tgt[2*i +: 2]), 64'(mdl_route(i)));
            chk(rq, $sformatf("bad_mask[%0d]", i), 64'(bad_mask[i]), 64'(mdl_bad(i)));
        end
    endtask

    task automatic sweep(input string rq);
        for (int t = 0; t < 256; t++) begin
            logic [7:0] h, s;
            logic [1:0] et;
            int         cnt;
            addr = {8'(t), t[0] ? 24'hFF_FFFF : 24'h00_0000};
            #1;
            h = mdl_hits(addr); s = '0; et = 2'd0; cnt = 0;
            for (int i = 7; i >= 0; i--) if (h[i]) begin s = 8'(1 << i); et = mdl_route(i); cnt++; end
            chk(rq, $sformatf("cs_sel @%08h", addr), 64'(cs_sel), 64'(s));
            chk({rq, "/R9"}, $sformatf("tgt @%08h", addr), 64'(tgt), 64'(et));
            chk({rq, "/R7"}, $sformatf("overlap @%08h", addr), 64'(overlap), 64'(cnt >= 2));
        end
    endtask

    initial begin
        #800_000;
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        pf_on = 1'b0; pf_cs = '0; zero_mask_ok = 1'b0; addr = '0;
        for (int i = 0; i < 8; i++) begin
            mb[i] = '0; mm[i] = 4'hF; mv[i] = (i == 0); mt[i] = 2'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents, observed through the decode
        addr = 32'h0012_3456; #1;
        chk("R1", "cs_sel low", 64'(cs_sel), 64'h01);
        chk("R1", "tgt low", 64'(tgt), 64'd1);
        addr = 32'h0100_0000; #1;
        chk("R1", "cs_sel next 16MB", 64'(cs_sel), 64'h00);
        chk_static("R1");
        sweep("R1/R2");

        // R3: every span code, R6: disabled window 5
        zero_mask_ok = 1'b1;
        wr_win(1, 32'h0000_0E42);
        wr_win(2, 32'h0000_0C44);
        wr_win(3, 32'h0000_0848);
        wr_win(4, 32'h0000_0050);
        wr_win(5, 32'h0000_0F30);
        chk_static("R3");
        sweep("R2/R3");

        // R6: clearing enable on window 3 removes it
        wr_win(3, 32'h0000_0808);
        sweep("R6");
        wr_win(3, 32'h0000_0848);

        // R7: overlapping windows, lowest wins
        wr_win(6, 32'h0000_0F45);
        wr_win(7, 32'h0000_0F40);
        addr = 32'h0500_0000; #1;
        chk("R7", "cs_sel overlap 2/6", 64'(cs_sel), 64'h04);
        chk("R7", "overlap 2/6", 64'(overlap), 64'd1);
        sweep("R7");

        // R5: ignored bits, rewrite with same kept bits
        wr_win(7, 32'h1234_5FF3);
        sweep("R5");
        wr_win(7, 32'hFFFF_FF73);
        addr = 32'h33AB_CDEF; #1;
        chk("R5", "cs_sel after no-op rewrite", 64'(cs_sel), 64'h80);
        sweep("R5");

        // R4: illegal codes
        zero_mask_ok = 1'b0;
        chk_static("R4");
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 1'b0; cfg_idx = 3'd5; cfg_wdata = 32'h0000_0530;
        @(negedge clk); cfg_we = 1'b0; mm[5] = 4'h5; mv[5] = 1'b0; mb[5] = 6'h30;
        chk_static("R4");
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 32'h0000_0570;
        @(negedge clk); cfg_we = 1'b0; mv[5] = 1'b1;
        chk_static("R4");
        wr_win(5, 32'h0000_0F30);
        zero_mask_ok = 1'b1;
        chk_static("R4");

        // R8: routing to NAND data and prefetch FIFO
        wr_dev(1, 32'h0000_0800);
        chk_static("R8");
        pf_on = 1'b1; pf_cs = 3'd1;
        chk_static("R8");
        sweep("R8");
        pf_cs = 3'd2;
        chk_static("R8");
        wr_dev(1, 32'h0000_0400);
        pf_cs = 3'd1;
        chk_static("R8");
        wr_dev(1, 32'hFFFF_F3FF);
        chk_static("R8");
        wr_dev(5, 32'h0000_0800);
        pf_cs = 3'd5;
        chk_static("R8");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule